// File: doc/BRIEF.md
# Per-Port Output Queue and Cell Readout

This block sits at the output side of a switch that keeps its frame data in a shared memory cut into fixed-size cells. For every output port it holds a small queue of cell descriptors. A descriptor is a cell number, an end-of-frame flag and, for the frame's final cell, the count of bytes used in that cell. The frame data itself never passes through the queues. The write side pushes descriptors in frame order. The block then streams each cell's words from the shared memory to the port that owns it.

A single read port of the shared memory is shared in time between all output ports. A round-robin scheduler picks one port among those that have a queued cell and signal ready. That port then keeps the memory for the whole cell. The read address is the cell number times the cell size in words, plus the word offset. The data comes back one cycle later, lined up with registered per-port strobes: write enable, start of packet and end of packet, plus a shared two-bit byte-valid code. Once the last word of a cell is out, its number is handed back to the free pool. When a port's queue is full, a new descriptor for that port is refused at once.

Top module: `egress_cell_reader`

## Requirements
- R1: Each output port has its own descriptor queue, and the cells of one port are delivered in the order their descriptors were accepted.
- R2: The words of a cell are read at address cell × CELL_WORDS + offset, with the offset counting up from 0 by one per delivered word.
- R3: A cell without the end-of-frame flag delivers CELL_WORDS words. A cell with the flag and a byte count b (1 to 4 × CELL_WORDS) delivers ceil(b/4) words.
- R4: `out_mod` on the final word of a frame equals b mod 4 (2'b00 meaning all four bytes valid). It is 2'b00 on every other delivered word.
- R5: `out_sop[p]` is high on the first word of the first cell after reset or after an end-of-frame cell of port p. `out_eop[p]` is high on the last word of an end-of-frame cell.
- R6: The read data is forwarded on `out_data` in the cycle after the read, together with the strobes that belong to that word.
- R7: The next port is picked round-robin among ports with a non-empty queue and ready high, starting at port 0 after reset. A picked port keeps the memory until its cell is finished, and at most one `out_wren` bit is high in any cycle.
- R8: No read is issued for port p while `port_ready[p]` is low. So `out_wren[p]` is high only in a cycle that follows a cycle with `port_ready[p]` high.
- R9: `free_valid` pulses together with the last word of each cell, and `free_cell` carries that cell's number.
- R10: An enqueue to a port whose queue holds Q_DEPTH descriptors raises `enq_refused` in the same cycle, and the refused descriptor is not stored.
- R11: After reset no strobe, no read and no cell return is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Descriptor push request |
| enq_port | input | PORT_W | Destination port of the descriptor |
| enq_cell | input | CELL_W | Cell number |
| enq_eof | input | 1 | Cell is the last of its frame |
| enq_bytes | input | BCNT_W | Bytes used in a last cell (1 to 4 × CELL_WORDS) |
| enq_refused | output | 1 | Destination queue full, push refused |
| port_ready | input | NUM_PORTS | Per-port ready to accept a word |
| mem_rd_en | output | 1 | Shared memory read strobe |
| mem_rd_addr | output | ADDR_W | Shared memory word address |
| mem_rd_data | input | DATA_W | Shared memory read data, one cycle after the read |
| out_data | output | DATA_W | Word delivered to the selected port |
| out_wren | output | NUM_PORTS | Per-port word valid |
| out_sop | output | NUM_PORTS | Per-port start of packet |
| out_eop | output | NUM_PORTS | Per-port end of packet |
| out_mod | output | 2 | Valid bytes of the final word, 00 for all four |
| free_valid | output | 1 | Cell return strobe |
| free_cell | output | CELL_W | Cell number being returned |

## Verification
Refusal is combinational, so the bench reads `enq_refused` one time step after it drives the push, inside the same cycle. The memory model answers one cycle after `mem_rd_en`, and the word, its strobes, the byte-valid code and the cell return all show up at that same edge. The bench samples all of them at the following falling edge and compares them there with a per-port model built from the descriptors it pushed. The ready check compares each `out_wren` bit with the ready value recorded at the previous falling edge, which is the value the design saw at the rising edge in between.

// File: rtl/egq_pkg.sv
package egq_pkg;
  typedef enum logic {
    ENG_IDLE = 1'b0,
    ENG_RUN  = 1'b1
  } eng_state_e;

  localparam int BYTES_PER_WORD = 4;
endpackage

// File: rtl/egq_cell_fifo.sv
module egq_cell_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n;
  logic [AW-1:0] rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push) begin
      wptr_n = (wptr_q == LAST_IDX) ? '0 : wptr_q + 1'b1;
    end
    if (pop) begin
      rptr_n = (rptr_q == LAST_IDX) ? '0 : rptr_q + 1'b1;
    end
    if (push && !pop) begin
      cnt_n = cnt_q + 1'b1;
    end else if (pop && !push) begin
      cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      store[wptr_q] <= push_data;
    end
  end

  assign head  = store[rptr_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULL_CNT);

  // R1: the read engine only pops a queue that holds a descriptor
  p_pop_nonempty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  // R10: the occupancy never passes the queue depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/egq_rr_arb.sv
module egq_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         req,
  input  logic                 advance,
  output logic                 gnt_valid,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int PW = $clog2(N);
  localparam logic [PW-1:0] START_PTR = PW'(N - 1);

  logic [PW-1:0] last_q, last_n;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    for (int i = 1; i <= N; i++) begin
      int cand;
      cand = (int'(last_q) + i) % N;
      if (!gnt_valid && req[cand]) begin
        gnt_valid = 1'b1;
        gnt_idx   = PW'(cand);
      end
    end
  end

  always_comb begin
    last_n = last_q;
    if (advance && gnt_valid) begin
      last_n = gnt_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= START_PTR;
    end else begin
      last_q <= last_n;
    end
  end

  // R7: a grant only goes to a requesting port
  p_grant_requested_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> req[gnt_idx]);

  // R7: after a grant is taken the priority pointer sits on that port
  p_pointer_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && gnt_valid) |=> (last_q == $past(gnt_idx)));
endmodule

// File: rtl/egq_read_engine.sv
module egq_read_engine
  import egq_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int CELL_W     = 6,
  parameter int CELL_WORDS = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         gnt_valid,
  input  logic [$clog2(NUM_PORTS)-1:0] gnt_idx,
  input  logic [CELL_W-1:0]            head_cell,
  input  logic                         head_eof,
  input  logic [$clog2(CELL_WORDS)+2:0] head_bytes,
  input  logic [NUM_PORTS-1:0]         port_ready,
  output logic                         take,
  output logic [NUM_PORTS-1:0]         pop_vec,
  output logic                         mem_rd_en,
  output logic [CELL_W+$clog2(CELL_WORDS)-1:0] mem_rd_addr,
  output logic [NUM_PORTS-1:0]         out_wren,
  output logic [NUM_PORTS-1:0]         out_sop,
  output logic [NUM_PORTS-1:0]         out_eop,
  output logic [1:0]                   out_mod,
  output logic                         free_valid,
  output logic [CELL_W-1:0]            free_cell
);
  localparam int PW     = $clog2(NUM_PORTS);
  localparam int OFS_W  = $clog2(CELL_WORDS);
  localparam int BCNT_W = OFS_W + 3;
  localparam int SUM_W  = BCNT_W + 2;
  localparam logic [OFS_W:0] NW_FULL = (OFS_W + 1)'(CELL_WORDS);

  eng_state_e             st_q, st_n;
  logic [PW-1:0]          sel_q, sel_n;
  logic [CELL_W-1:0]      cell_q, cell_n;
  logic                   eof_q, eof_n;
  logic [1:0]             tail_q, tail_n;
  logic [OFS_W:0]         nw_q, nw_n;
  logic [OFS_W-1:0]       ofs_q, ofs_n;
  logic [NUM_PORTS-1:0]   sof_q, sof_n;

  logic [NUM_PORTS-1:0]   wren_n, sop_n, eop_n;
  logic [1:0]             mod_n;
  logic                   fv_n;
  logic [CELL_W-1:0]      fc_n;
  logic [NUM_PORTS-1:0]   wren_q, sop_q, eop_q;
  logic [1:0]             mod_q;
  logic                   fv_q;
  logic [CELL_W-1:0]      fc_q;

  logic                   fire;
  logic                   last_word;
  logic [NUM_PORTS-1:0]   sel_hot;
  logic [SUM_W-1:0]       byte_sum;
  logic [OFS_W:0]         head_words;

  assign byte_sum   = SUM_W'(head_bytes) + SUM_W'(BYTES_PER_WORD - 1);
  assign head_words = byte_sum[OFS_W+2:2];
  assign sel_hot    = NUM_PORTS'(1) << sel_q;
  assign fire       = (st_q == ENG_RUN) && port_ready[sel_q];
  assign last_word  = ({1'b0, ofs_q} == (nw_q - 1'b1));

  always_comb begin
    st_n   = st_q;
    sel_n  = sel_q;
    cell_n = cell_q;
    eof_n  = eof_q;
    tail_n = tail_q;
    nw_n   = nw_q;
    ofs_n  = ofs_q;
    sof_n  = sof_q;
    take   = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (gnt_valid) begin
          take   = 1'b1;
          st_n   = ENG_RUN;
          sel_n  = gnt_idx;
          cell_n = head_cell;
          eof_n  = head_eof;
          tail_n = head_bytes[1:0];
          nw_n   = head_eof ? head_words : NW_FULL;
          ofs_n  = '0;
        end
      end
      ENG_RUN: begin
        if (fire) begin
          if (last_word) begin
            st_n         = ENG_IDLE;
            ofs_n        = '0;
            sof_n[sel_q] = eof_q;
          end else begin
            ofs_n = ofs_q + 1'b1;
          end
        end
      end
      default: st_n = ENG_IDLE;
    endcase
  end

  always_comb begin
    wren_n = fire ? sel_hot : '0;
    sop_n  = (fire && (ofs_q == '0) && sof_q[sel_q]) ? sel_hot : '0;
    eop_n  = (fire && last_word && eof_q) ? sel_hot : '0;
    mod_n  = (fire && last_word && eof_q) ? tail_q : 2'b00;
    fv_n   = fire && last_word;
    fc_n   = fv_n ? cell_q : fc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      sel_q  <= '0;
      cell_q <= '0;
      eof_q  <= 1'b0;
      tail_q <= '0;
      nw_q   <= '0;
      ofs_q  <= '0;
      sof_q  <= '1;
      wren_q <= '0;
      sop_q  <= '0;
      eop_q  <= '0;
      mod_q  <= '0;
      fv_q   <= 1'b0;
      fc_q   <= '0;
    end else begin
      st_q   <= st_n;
      sel_q  <= sel_n;
      cell_q <= cell_n;
      eof_q  <= eof_n;
      tail_q <= tail_n;
      nw_q   <= nw_n;
      ofs_q  <= ofs_n;
      sof_q  <= sof_n;
      wren_q <= wren_n;
      sop_q  <= sop_n;
      eop_q  <= eop_n;
      mod_q  <= mod_n;
      fv_q   <= fv_n;
      fc_q   <= fc_n;
    end
  end

  assign pop_vec     = (fire && last_word) ? sel_hot : '0;
  assign mem_rd_en   = fire;
  assign mem_rd_addr = {cell_q, ofs_q};
  assign out_wren    = wren_q;
  assign out_sop     = sop_q;
  assign out_eop     = eop_q;
  assign out_mod     = mod_q;
  assign free_valid  = fv_q;
  assign free_cell   = fc_q;

  // R3: the word offset stays inside the words owed for the current cell
  p_ofs_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_RUN) |-> ({1'b0, ofs_q} < nw_q));

  // R4: a non-zero byte code only appears with an end of packet
  p_mod_only_at_eop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mod != 2'b00) |-> (out_eop != '0));

  // R5: packet delimiters only appear on a delivered word
  p_marks_with_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_sop | out_eop) & ~out_wren) == '0);

  // R6: every read is followed by exactly one delivered word
  p_word_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (out_wren != '0));

  // R7: one port at a time on the shared output
  p_wren_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_wren));

  // R8: a word for a port follows a cycle in which that port was ready
  p_wren_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_wren != '0) |-> ((out_wren & $past(port_ready)) == out_wren));

  // R9: an end of packet always returns its cell
  p_eop_returns_cell_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_eop != '0) |-> free_valid);
endmodule

// File: rtl/egress_cell_reader.sv
module egress_cell_reader #(
  parameter int NUM_PORTS  = 4,
  parameter int CELL_W     = 6,
  parameter int CELL_WORDS = 64,
  parameter int Q_DEPTH    = 8,
  parameter int DATA_W     = 32,
  localparam int PORT_W    = $clog2(NUM_PORTS),
  localparam int OFS_W     = $clog2(CELL_WORDS),
  localparam int BCNT_W    = OFS_W + 3,
  localparam int ADDR_W    = CELL_W + OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enq_valid,
  input  logic [PORT_W-1:0]    enq_port,
  input  logic [CELL_W-1:0]    enq_cell,
  input  logic                 enq_eof,
  input  logic [BCNT_W-1:0]    enq_bytes,
  output logic                 enq_refused,
  input  logic [NUM_PORTS-1:0] port_ready,
  output logic                 mem_rd_en,
  output logic [ADDR_W-1:0]    mem_rd_addr,
  input  logic [DATA_W-1:0]    mem_rd_data,
  output logic [DATA_W-1:0]    out_data,
  output logic [NUM_PORTS-1:0] out_wren,
  output logic [NUM_PORTS-1:0] out_sop,
  output logic [NUM_PORTS-1:0] out_eop,
  output logic [1:0]           out_mod,
  output logic                 free_valid,
  output logic [CELL_W-1:0]    free_cell
);
  localparam int ENTRY_W = CELL_W + 1 + BCNT_W;

  logic [ENTRY_W-1:0]   head_vec [NUM_PORTS];
  logic [NUM_PORTS-1:0] q_empty, q_full, q_push, q_pop;
  logic [ENTRY_W-1:0]   enq_entry;
  logic                 gnt_valid, take;
  logic [PORT_W-1:0]    gnt_idx;
  logic [ENTRY_W-1:0]   gnt_entry;

  assign enq_entry   = {enq_cell, enq_eof, enq_bytes};
  assign enq_refused = enq_valid && q_full[enq_port];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_queue
    assign q_push[p] = enq_valid && (enq_port == PORT_W'(p)) && !q_full[p];
    egq_cell_fifo #(
      .W     (ENTRY_W),
      .DEPTH (Q_DEPTH)
    ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (q_push[p]),
      .push_data (enq_entry),
      .pop       (q_pop[p]),
      .head      (head_vec[p]),
      .empty     (q_empty[p]),
      .full      (q_full[p])
    );
  end

  egq_rr_arb #(
    .N (NUM_PORTS)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (~q_empty & port_ready),
    .advance   (take),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx)
  );

  assign gnt_entry = head_vec[gnt_idx];

  egq_read_engine #(
    .NUM_PORTS  (NUM_PORTS),
    .CELL_W     (CELL_W),
    .CELL_WORDS (CELL_WORDS)
  ) u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_valid   (gnt_valid),
    .gnt_idx     (gnt_idx),
    .head_cell   (gnt_entry[ENTRY_W-1 -: CELL_W]),
    .head_eof    (gnt_entry[BCNT_W]),
    .head_bytes  (gnt_entry[BCNT_W-1:0]),
    .port_ready  (port_ready),
    .take        (take),
    .pop_vec     (q_pop),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .out_wren    (out_wren),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_mod     (out_mod),
    .free_valid  (free_valid),
    .free_cell   (free_cell)
  );

  assign out_data = mem_rd_data;

  // R10: a refusal only happens when a push is presented
  p_refuse_needs_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    enq_refused |-> (enq_valid && (q_push == '0)));

  // R11: nothing is read or returned while every queue is empty and idle
  p_quiet_when_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(q_empty) == '1 && $past(mem_rd_en) == 1'b0 && q_empty == '1) |-> !mem_rd_en);
endmodule

// File: tb/egress_cell_reader_tb.sv
module egress_cell_reader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int CW   = 8;
  localparam int CBW  = 5;
  localparam int QD   = 4;
  localparam int DW   = 32;
  localparam int PW   = 2;
  localparam int BW   = 6;
  localparam int AW   = 8;
  localparam int LOGN = 256;

  logic clk, rst_n;
  logic enq_valid;
  logic [PW-1:0] enq_port;
  logic [CBW-1:0] enq_cell;
  logic enq_eof;
  logic [BW-1:0] enq_bytes;
  logic enq_refused;
  logic [NP-1:0] port_ready;
  logic mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [DW-1:0] mem_rd_data;
  logic [DW-1:0] out_data;
  logic [NP-1:0] out_wren, out_sop, out_eop;
  logic [1:0] out_mod;
  logic free_valid;
  logic [CBW-1:0] free_cell;

  egress_cell_reader #(
    .NUM_PORTS(NP), .CELL_W(CBW), .CELL_WORDS(CW), .Q_DEPTH(QD), .DATA_W(DW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_port(enq_port),
    .enq_cell(enq_cell), .enq_eof(enq_eof), .enq_bytes(enq_bytes),
    .enq_refused(enq_refused), .port_ready(port_ready), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .out_data(out_data),
    .out_wren(out_wren), .out_sop(out_sop), .out_eop(out_eop), .out_mod(out_mod),
    .free_valid(free_valid), .free_cell(free_cell)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int rmode   = 0;
  bit mon_on  = 0;
  bit done    = 0;

  int ecell [NP][LOGN];
  bit eeof  [NP][LOGN];
  int ebyte [NP][LOGN];
  int wcnt [NP];
  int rcnt [NP];
  int wpos [NP];
  bit sofp [NP];
  logic [NP-1:0] rdy_prev;
  int slog [LOGN];
  int slog_n = 0;
  int next_cell = 0;

  function automatic logic [DW-1:0] memf(input int a);
    return (DW'(a) * 32'h0100_0193) ^ 32'h5BD1_E995;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rd_data <= memf(int'(mem_rd_addr));
  end

  always @(posedge clk) begin
    #1;
    case (rmode)
      0: port_ready = '0;
      1: port_ready = '1;
      default: begin
        for (int p = 0; p < NP; p++)
          port_ready[p] = (((cyc * 7) + (p * 3)) % 5) != 0;
      end
    endcase
  end

  always @(negedge clk) begin
    int nact;
    if (rst_n && mon_on) begin
      nact = 0;
      for (int p = 0; p < NP; p++) if (out_wren[p]) nact++;
      if (nact > 1) chk(0, "R7 several ports in one cycle", nact, 1);
      if (free_valid && out_wren == '0) chk(0, "R9 return without a word", 1, 0);
      for (int p = 0; p < NP; p++) begin
        if (out_wren[p]) begin
          int k, c, b, nw, w;
          bit eo, lst;
          k = rcnt[p];
          chk(rdy_prev[p], "R8 word without prior ready", 0, 1);
          for (int q = 0; q < NP; q++)
            if (q != p && wpos[q] != 0) chk(0, "R7 cell interrupted by another port", q, p);
          if (k >= wcnt[p]) begin
            chk(0, "R1 word with no queued cell", k, wcnt[p]);
          end else begin
            c  = ecell[p][k];
            eo = eeof[p][k];
            b  = ebyte[p][k];
            nw = eo ? (b + 3) / 4 : CW;
            w  = wpos[p];
            lst = (w == nw - 1);
            chk(out_data == memf(c * CW + w), "R2 R6 word data", int'(out_data), int'(memf(c * CW + w)));
            chk(out_sop[p] == (w == 0 && sofp[p]), "R5 start of packet", out_sop[p], (w == 0 && sofp[p]));
            chk(out_eop[p] == (lst && eo), "R5 R3 end of packet", out_eop[p], (lst && eo));
            chk(int'(out_mod) == ((lst && eo) ? b % 4 : 0), "R4 byte code", out_mod, (lst && eo) ? b % 4 : 0);
            chk(free_valid == lst, "R9 R3 return strobe", free_valid, lst);
            if (lst) chk(int'(free_cell) == c, "R9 returned cell", free_cell, c);
            if (w == 0 && slog_n < LOGN) begin
              slog[slog_n] = p;
              slog_n++;
            end
            if (lst) begin
              wpos[p] = 0;
              rcnt[p] = k + 1;
              sofp[p] = eo;
            end else begin
              wpos[p] = w + 1;
            end
          end
        end
      end
    end
    rdy_prev = port_ready;
  end

  task automatic enq_raw(input int p, input int c, input bit eo, input int b, output bit refused);
    @(posedge clk);
    #2;
    enq_valid = 1'b1;
    enq_port  = PW'(p);
    enq_cell  = CBW'(c);
    enq_eof   = eo;
    enq_bytes = BW'(b);
    #1;
    refused = enq_refused;
    if (!refused) begin
      ecell[p][wcnt[p]] = c;
      eeof[p][wcnt[p]]  = eo;
      ebyte[p][wcnt[p]] = b;
      wcnt[p]++;
    end
    @(posedge clk);
    #2;
    enq_valid = 1'b0;
  endtask

  task automatic enq(input int p, input bit eo, input int b);
    bit r;
    while (wcnt[p] - rcnt[p] >= QD) @(negedge clk);
    enq_raw(p, next_cell, eo, b, r);
    chk(!r, "R10 refusal with space left", r, 0);
    next_cell = (next_cell + 1) % (1 << CBW);
  endtask

  task automatic drain(input string tag);
    int lim;
    bit all;
    lim = 0;
    all = 0;
    while (!all && lim < 20000) begin
      @(negedge clk);
      lim++;
      all = 1;
      for (int p = 0; p < NP; p++) if (rcnt[p] != wcnt[p] || wpos[p] != 0) all = 0;
    end
    for (int p = 0; p < NP; p++) chk(rcnt[p] == wcnt[p], tag, rcnt[p], wcnt[p]);
  endtask

  initial begin
    int guard;
    guard = 0;
    while (!done) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        chk(0, "watchdog expired", guard, 150000);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    bit r;
    int base;
    rst_n = 1'b0;
    enq_valid = 1'b0;
    enq_port = '0;
    enq_cell = '0;
    enq_eof = 1'b0;
    enq_bytes = '0;
    port_ready = '0;
    mem_rd_data = '0;
    for (int p = 0; p < NP; p++) begin
      wcnt[p] = 0; rcnt[p] = 0; wpos[p] = 0; sofp[p] = 1;
    end
    rdy_prev = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R11: quiet after reset
    chk(out_wren == '0 && out_sop == '0 && out_eop == '0, "R11 strobes after reset", out_wren, 0);
    chk(!free_valid && !mem_rd_en, "R11 no read or return after reset", {free_valid, mem_rd_en}, 0);
    chk(!enq_refused, "R11 no refusal after reset", enq_refused, 0);
    mon_on = 1;

    // R7: round robin order with every port loaded while ready is low
    rmode = 0;
    for (int rnd = 0; rnd < 2; rnd++)
      for (int p = 0; p < NP; p++) enq(p, 1'b1, 4 + 4 * p);
    repeat (4) @(negedge clk);
    chk(slog_n == 0, "R8 nothing delivered with ready low", slog_n, 0);
    base = slog_n;
    rmode = 1;
    drain("R1 R7 round robin drain");
    for (int i = 0; i < 2 * NP; i++)
      chk(slog[base + i] == i % NP, "R7 service order", slog[base + i], i % NP);

    // R10: fill one queue with ready low, the next push is refused
    rmode = 0;
    for (int i = 0; i < QD; i++) begin
      enq_raw(3, 10 + i, 1'b1, 32, r);
      chk(!r, "R10 accepted while space left", r, 0);
    end
    enq_raw(3, 20, 1'b1, 32, r);
    chk(r, "R10 full queue refuses push", r, 1);
    rmode = 1;
    drain("R10 refused descriptor not delivered");

    // R3 R4 R5: every last-cell byte count in two-cell frames, throttled ready
    rmode = 2;
    for (int b = 1; b <= 4 * CW; b++) begin
      enq(b % NP, 1'b0, 0);
      enq(b % NP, 1'b1, b);
    end
    drain("R3 two-cell frame sweep");

    // R5: a long frame of three cells then single-cell frames on one port
    for (int b = 1; b <= 8; b++) begin
      enq(1, 1'b0, 0);
      enq(1, 1'b0, 0);
      enq(1, 1'b1, b * 3);
      enq(2, 1'b1, b);
    end
    drain("R5 mixed frame lengths");

    rmode = 1;
    repeat (3) @(negedge clk);
    chk(!free_valid && out_wren == '0, "R9 idle after drain", free_valid, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule